// File: doc/BRIEF.md
# Debug channel interrupt-enable register

This block holds the two interrupt-enable controls of a debug communications channel that has a receive mailbox and a transmit mailbox. It drives one combined interrupt line. The receive condition asserts it while the receive mailbox holds data. The transmit condition asserts it while the transmit mailbox has room. Each condition counts only when its enable bit is set. The two status flags come straight from the mailboxes and reach the interrupt line with no register delay.

Software reaches the register through a system-register access port. A request carries a 16-bit encoding, a read/write flag, 64-bit write data and the current privilege level (0 to 3). The block checks the privilege level and a set of trap-control bits from higher levels, in a fixed priority order. Each selected request gets one of three results: the access completes, it is undefined, or it traps to level 2 or level 3 with syndrome class 0x18. The result appears on registered response outputs in the cycle after the request. Requests with any other encoding belong to other registers and get no response.

Top module: `dchan_irqen_reg`

## Requirements
- R1: A synchronous active-high reset (`rst`) clears both enables and all response outputs. After reset `irq` stays 0 for any status-flag values, and a read returns 0.
- R2: Write-data bit 30 is the receive enable. While it is 1, `irq` is 1 whenever `rx_full` is 1.
- R3: Write-data bit 29 is the transmit enable. While it is 1, `irq` is 1 whenever `tx_full` is 0.
- R4: `irq` is the OR of the two enabled conditions. A change of `rx_full` or `tx_full` shows on `irq` in the same cycle.
- R5: Bits 63:31 and 28:0 always read as 0, and writing them has no effect.
- R6: The register is selected only when `acc_enc` = {op0[15:14], op1[13:11], crn[10:7], crm[6:3], op2[2:0]} = 16'h8010 (op0=2, crm=2, the other fields 0). Any other encoding produces no response and leaves the enables unchanged.
- R7: A selected access at level 0 sets `rsp_undef`. It neither reads nor writes the register.
- R8: At level 1, the checks run in this order, and the first one that matches traps:
  - `l2_comm_trap` traps to level 2.
  - `l2_dbgexc_trap` OR `l2_dbgacc_trap` traps to level 2.
  - `l3_comm_trap` traps to level 3.
  - `l3_dbgacc_trap` traps to level 3.
  - If none of them matches, the access completes.
- R9: The level-2 checks apply only when `el2_enabled` and `el2_is64` are both 1. The level-3 checks apply only when `el3_present` and `el3_is64` are both 1.
- R10: At level 2, only the two level-3 checks apply, in the same order. At level 3, an access always completes.
- R11: A trap sets `rsp_trap`, puts the target level (2 or 3) on `rsp_trap_el` and puts 0x18 on `rsp_class`.
- R12: Each selected request produces exactly one of `rsp_done`, `rsp_undef` or `rsp_trap`, for one cycle, in the cycle after the request.
  - `rsp_rdata` carries the register value only for a completed read. In every other case it is 0.
  - A trapped or undefined access leaves the enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high warm reset |
| acc_valid | input | 1 | Access request, one cycle per request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_enc | input | 16 | Access encoding {op0, op1, crn, crm, op2} |
| acc_wdata | input | 64 | Write data |
| acc_el | input | 2 | Current privilege level |
| el2_enabled | input | 1 | Level 2 is enabled |
| el2_is64 | input | 1 | Level 2 runs in the 64-bit state |
| el3_present | input | 1 | Level 3 is implemented |
| el3_is64 | input | 1 | Level 3 runs in the 64-bit state |
| l2_comm_trap | input | 1 | Level-2 trap control for channel registers |
| l2_dbgexc_trap | input | 1 | Level-2 trap control for debug exceptions |
| l2_dbgacc_trap | input | 1 | Level-2 trap control for debug register access |
| l3_comm_trap | input | 1 | Level-3 trap control for channel registers |
| l3_dbgacc_trap | input | 1 | Level-3 trap control for debug register access |
| rx_full | input | 1 | Receive mailbox holds data |
| tx_full | input | 1 | Transmit mailbox is full |
| rsp_done | output | 1 | Access completed |
| rsp_undef | output | 1 | Access undefined |
| rsp_trap | output | 1 | Access trapped |
| rsp_trap_el | output | 2 | Trap target level |
| rsp_class | output | 6 | Trap syndrome class |
| rsp_rdata | output | 64 | Read data |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a level-1 access where a lower-priority trap bit is set at the same time as a higher-priority one, or where a matching trap bit is masked because its level is disabled or not in the 64-bit state. Random stimulus would reach the exact combination that separates one priority order from another only rarely. The bench therefore walks directed cases through every priority step, each with all lower-priority bits also set, and each gating pair with one half cleared. It then runs several hundred random accesses over every level and every trap-control pattern against a bench-side model of the priority rules. After each access it checks the interrupt under freshly randomised status flags.

// File: rtl/dchan_pkg.sv
package dchan_pkg;

    localparam int DATA_W     = 64;
    localparam int RX_BIT     = 30;
    localparam int TX_BIT     = 29;
    localparam int CLASS_W    = 6;
    localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h18;

    typedef enum logic [1:0] {PRIV_L0, PRIV_L1, PRIV_L2, PRIV_L3} priv_e;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysenc_t;

    localparam sysenc_t SEL_ENC = '{op0: 2'd2, op1: 3'd0, crn: 4'd0, crm: 4'd2, op2: 3'd0};

    typedef struct packed {
        logic el2_on;
        logic el2_wide;
        logic el3_on;
        logic el3_wide;
        logic l2_comm;
        logic l2_dexc;
        logic l2_dacc;
        logic l3_comm;
        logic l3_dacc;
    } trapcfg_t;

    typedef enum logic [1:0] {OUT_NONE, OUT_DONE, OUT_UNDEF, OUT_TRAP} outcome_e;

    typedef struct packed {
        outcome_e kind;
        priv_e    target;
    } verdict_t;

    function automatic verdict_t judge(input priv_e lvl, input trapcfg_t c);
        verdict_t v;
        logic l2_live;
        logic l3_live;
        l2_live  = c.el2_on & c.el2_wide;
        l3_live  = c.el3_on & c.el3_wide;
        v.kind   = OUT_DONE;
        v.target = PRIV_L0;
        unique case (lvl)
            PRIV_L0: v.kind = OUT_UNDEF;
            PRIV_L1: begin
                if (l2_live && (c.l2_comm || c.l2_dexc || c.l2_dacc)) begin
                    v.kind = OUT_TRAP; v.target = PRIV_L2;
                end else if (l3_live && (c.l3_comm || c.l3_dacc)) begin
                    v.kind = OUT_TRAP; v.target = PRIV_L3;
                end
            end
            PRIV_L2: begin
                if (l3_live && (c.l3_comm || c.l3_dacc)) begin
                    v.kind = OUT_TRAP; v.target = PRIV_L3;
                end
            end
            default: v.kind = OUT_DONE;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/dchan_access_check.sv
module dchan_access_check
    import dchan_pkg::*;
(
    input  logic     valid,
    input  sysenc_t  enc,
    input  priv_e    lvl,
    input  trapcfg_t cfg,
    output verdict_t verdict
);
    logic selected;
    assign selected = valid && (enc == SEL_ENC);

    always_comb begin
        if (selected) verdict = judge(lvl, cfg);
        else          verdict = '{kind: OUT_NONE, target: PRIV_L0};
    end
endmodule

// File: rtl/dchan_enable_store.sv
module dchan_enable_store #(
    parameter int DATA_W = 64,
    parameter int RX_BIT = 30,
    parameter int TX_BIT = 29
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_rx,
    input  logic              wr_tx,
    output logic              en_rx,
    output logic              en_tx,
    output logic [DATA_W-1:0] rd_word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_rx <= 1'b0;
            en_tx <= 1'b0;
        end else if (wr_en) begin
            en_rx <= wr_rx;
            en_tx <= wr_tx;
        end
    end

    always_comb begin
        rd_word         = '0;
        rd_word[RX_BIT] = en_rx;
        rd_word[TX_BIT] = en_tx;
    end

    // R12: enables move only on a completed write
    assert_hold_without_write_R12: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable({en_rx, en_tx}));
endmodule

// File: rtl/dchan_irq_merge.sv
module dchan_irq_merge #(
    parameter int          NSRC     = 2,
    parameter logic [NSRC-1:0] ACT_HIGH = 2'b01
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] flag,
    output logic            irq
);
    logic [NSRC-1:0] hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (ACT_HIGH[i]) begin : g_hi
            assign hit[i] = en[i] & flag[i];
        end else begin : g_lo
            assign hit[i] = en[i] & ~flag[i];
        end
    end

    assign irq = |hit;

    // R4: no interrupt unless some enable is set
    assert_quiet_when_disabled_R4: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq);
endmodule

// File: rtl/dchan_irqen_reg.sv
module dchan_irqen_reg
    import dchan_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int RXB   = RX_BIT,
    parameter int TXB   = TX_BIT,
    parameter int CW    = CLASS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [15:0]   acc_enc,
    input  logic [DW-1:0] acc_wdata,
    input  logic [1:0]    acc_el,
    input  logic          el2_enabled,
    input  logic          el2_is64,
    input  logic          el3_present,
    input  logic          el3_is64,
    input  logic          l2_comm_trap,
    input  logic          l2_dbgexc_trap,
    input  logic          l2_dbgacc_trap,
    input  logic          l3_comm_trap,
    input  logic          l3_dbgacc_trap,
    input  logic          rx_full,
    input  logic          tx_full,
    output logic          rsp_done,
    output logic          rsp_undef,
    output logic          rsp_trap,
    output logic [1:0]    rsp_trap_el,
    output logic [CW-1:0] rsp_class,
    output logic [DW-1:0] rsp_rdata,
    output logic          irq
);
    trapcfg_t        cfg;
    verdict_t        verdict;
    logic            en_rx, en_tx;
    logic [DW-1:0]   rd_word;
    logic            wr_en;
    logic            unused_wbits;

    assign cfg = '{el2_on: el2_enabled, el2_wide: el2_is64,
                   el3_on: el3_present, el3_wide: el3_is64,
                   l2_comm: l2_comm_trap, l2_dexc: l2_dbgexc_trap, l2_dacc: l2_dbgacc_trap,
                   l3_comm: l3_comm_trap, l3_dacc: l3_dbgacc_trap};

    dchan_access_check u_check (
        .valid   (acc_valid),
        .enc     (sysenc_t'(acc_enc)),
        .lvl     (priv_e'(acc_el)),
        .cfg     (cfg),
        .verdict (verdict)
    );

    assign wr_en        = (verdict.kind == OUT_DONE) && acc_write;
    assign unused_wbits = ^acc_wdata;

    dchan_enable_store #(.DATA_W(DW), .RX_BIT(RXB), .TX_BIT(TXB)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_rx   (acc_wdata[RXB]),
        .wr_tx   (acc_wdata[TXB]),
        .en_rx   (en_rx),
        .en_tx   (en_tx),
        .rd_word (rd_word)
    );

    dchan_irq_merge #(.NSRC(2), .ACT_HIGH(2'b01)) u_merge (
        .clk  (clk),
        .rst  (rst),
        .en   ({en_tx, en_rx}),
        .flag ({tx_full, rx_full}),
        .irq  (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done    <= 1'b0;
            rsp_undef   <= 1'b0;
            rsp_trap    <= 1'b0;
            rsp_trap_el <= '0;
            rsp_class   <= '0;
            rsp_rdata   <= '0;
        end else begin
            rsp_done    <= verdict.kind == OUT_DONE;
            rsp_undef   <= verdict.kind == OUT_UNDEF;
            rsp_trap    <= verdict.kind == OUT_TRAP;
            rsp_trap_el <= (verdict.kind == OUT_TRAP) ? verdict.target : 2'd0;
            rsp_class   <= (verdict.kind == OUT_TRAP) ? TRAP_CLASS[CW-1:0] : '0;
            rsp_rdata   <= (verdict.kind == OUT_DONE && !acc_write) ? rd_word : '0;
        end
    end

    // R12: at most one outcome per cycle
    assert_single_outcome_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_done, rsp_undef, rsp_trap}));
    // R12: outcomes follow a request by one cycle
    assert_rsp_after_req_R12: assert property (@(posedge clk) disable iff (rst)
        (rsp_done || rsp_undef || rsp_trap) |-> $past(acc_valid));
    // R11: trap target is level 2 or 3 with fixed class
    assert_trap_fields_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_trap |-> (rsp_trap_el[1] && rsp_class == TRAP_CLASS[CW-1:0]));
    // R10: level 3 never traps or faults
    assert_top_level_completes_R10: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_el == 2'd3 && sysenc_t'(acc_enc) == SEL_ENC) |=> rsp_done);
    // R5: reserved read bits are zero
    assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_rdata & ~((DW'(1) << RXB) | (DW'(1) << TXB))) == '0);
    // R7: level 0 gives undefined
    assert_low_level_undef_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_el == 2'd0 && sysenc_t'(acc_enc) == SEL_ENC) |=> rsp_undef);
endmodule

// File: tb/dchan_irqen_reg_test.sv
module dchan_irqen_reg_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid, acc_write;
    logic [15:0] acc_enc;
    logic [63:0] acc_wdata;
    logic [1:0]  acc_el;
    logic [8:0]  cfg; // {el2_en, el2_64, el3_p, el3_64, l2c, l2x, l2a, l3c, l3a}
    logic        rx_full, tx_full;
    logic        rsp_done, rsp_undef, rsp_trap, irq;
    logic [1:0]  rsp_trap_el;
    logic [5:0]  rsp_class;
    logic [63:0] rsp_rdata;

    int checks = 0, fails = 0;
    logic m_rx = 0, m_tx = 0;
    localparam logic [15:0] SEL = 16'h8010;

    always #10 clk = ~clk;

    dchan_irqen_reg uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_enc(acc_enc), .acc_wdata(acc_wdata), .acc_el(acc_el),
        .el2_enabled(cfg[8]), .el2_is64(cfg[7]), .el3_present(cfg[6]), .el3_is64(cfg[5]),
        .l2_comm_trap(cfg[4]), .l2_dbgexc_trap(cfg[3]), .l2_dbgacc_trap(cfg[2]),
        .l3_comm_trap(cfg[1]), .l3_dbgacc_trap(cfg[0]),
        .rx_full(rx_full), .tx_full(tx_full),
        .rsp_done(rsp_done), .rsp_undef(rsp_undef), .rsp_trap(rsp_trap),
        .rsp_trap_el(rsp_trap_el), .rsp_class(rsp_class), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // outcome code: 0 none, 1 done, 2 undef, 3 trap; tgt = trap level
    function automatic int expect_kind(input logic [15:0] e, input logic [1:0] el,
                                       input logic [8:0] c, output int tgt);
        bit l2 = c[8] & c[7];
        bit l3 = c[6] & c[5];
        tgt = 0;
        if (e != SEL) return 0;
        if (el == 2'd0) return 2;
        if (el == 2'd1) begin
            if (l2 && c[4]) begin tgt = 2; return 3; end
            if (l2 && (c[3] | c[2])) begin tgt = 2; return 3; end
        end
        if (el == 2'd1 || el == 2'd2) begin
            if (l3 && c[1]) begin tgt = 3; return 3; end
            if (l3 && c[0]) begin tgt = 3; return 3; end
        end
        return 1;
    endfunction

    function automatic bit model_irq(input logic rxf, input logic txf);
        return (m_rx & rxf) | (m_tx & ~txf);
    endfunction

    task automatic check_irq(input string req);
        for (int k = 0; k < 4; k++) begin
            rx_full = k[0]; tx_full = k[1];
            #1;
            chk(irq == model_irq(rx_full, tx_full), req, "irq", 64'(irq), 64'(model_irq(rx_full, tx_full)));
        end
    endtask

    task automatic access(input logic [15:0] e, input logic [1:0] el, input logic w,
                          input logic [63:0] wd, input string req);
        int kind, tgt;
        logic [63:0] exp_rd;
        @(negedge clk);
        acc_valid = 1; acc_enc = e; acc_el = el; acc_write = w; acc_wdata = wd;
        kind = expect_kind(e, el, cfg, tgt);
        exp_rd = (kind == 1 && !w) ? {33'd0, m_rx, m_tx, 29'd0} : 64'd0;
        @(negedge clk);
        acc_valid = 0;
        chk({rsp_done, rsp_undef, rsp_trap} == {kind == 1, kind == 2, kind == 3}, req, "outcome",
            64'({rsp_done, rsp_undef, rsp_trap}), 64'({kind == 1, kind == 2, kind == 3}));
        chk(rsp_rdata == exp_rd, req, "rdata", rsp_rdata, exp_rd);
        if (kind == 3) begin
            chk(rsp_trap_el == 2'(tgt) && rsp_class == 6'h18, "R11", "trap fields",
                64'({rsp_trap_el, rsp_class}), 64'({2'(tgt), 6'h18}));
        end
        if (kind == 1 && w) begin m_rx = wd[30]; m_tx = wd[29]; end
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7151));
        rst = 1; acc_valid = 0; acc_write = 0; acc_enc = 0; acc_wdata = 0; acc_el = 0;
        cfg = 0; rx_full = 0; tx_full = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk({rsp_done, rsp_undef, rsp_trap} == 0, "R1", "rsp after reset", 64'({rsp_done, rsp_undef, rsp_trap}), 0);
        check_irq("R1");
        access(SEL, 2'd3, 0, 0, "R1");
        // R2/R3/R4: enables individually and together
        access(SEL, 2'd3, 1, 64'h4000_0000, "R2"); check_irq("R2");
        access(SEL, 2'd3, 1, 64'h2000_0000, "R3"); check_irq("R3");
        access(SEL, 2'd3, 1, 64'h6000_0000, "R4"); check_irq("R4");
        // R5: reserved bits
        access(SEL, 2'd3, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
        access(SEL, 2'd3, 0, 0, "R5");
        access(SEL, 2'd3, 1, 64'hFFFF_FFFF_9FFF_FFFF, "R5");
        access(SEL, 2'd3, 0, 0, "R5"); check_irq("R5");
        // R6: other encodings ignored
        access(SEL, 2'd3, 1, 64'h6000_0000, "R6");
        access(16'h8018, 2'd3, 1, 0, "R6");
        access(16'h8011, 2'd3, 1, 0, "R6");
        access(16'hC010, 2'd1, 1, 0, "R6");
        access(SEL, 2'd3, 0, 0, "R6"); check_irq("R6");
        // R7: level 0
        access(SEL, 2'd0, 1, 0, "R7"); check_irq("R7");
        // R8: priority at level 1, lower bits also set
        cfg = 9'b1111_11111; access(SEL, 2'd1, 1, 0, "R8");
        cfg = 9'b1111_01111; access(SEL, 2'd1, 1, 0, "R8");
        cfg = 9'b1111_00111; access(SEL, 2'd1, 1, 0, "R8");
        cfg = 9'b1111_00011; access(SEL, 2'd1, 1, 0, "R8");
        cfg = 9'b1111_00001; access(SEL, 2'd1, 1, 0, "R8");
        cfg = 9'b1111_00000; access(SEL, 2'd1, 1, 64'h4000_0000, "R8");
        // R9: gating
        cfg = 9'b0111_11111; access(SEL, 2'd1, 0, 0, "R9");
        cfg = 9'b1011_11100; access(SEL, 2'd1, 0, 0, "R9");
        cfg = 9'b0010_11111; access(SEL, 2'd1, 0, 0, "R9");
        cfg = 9'b0001_00011; access(SEL, 2'd1, 0, 0, "R9");
        // R10: level 2 and 3
        cfg = 9'b1111_11100; access(SEL, 2'd2, 1, 64'h2000_0000, "R10");
        cfg = 9'b1111_11110; access(SEL, 2'd2, 1, 0, "R10");
        cfg = 9'b1111_11111; access(SEL, 2'd3, 0, 0, "R10");
        check_irq("R12");
        // R12: random mix
        for (int i = 0; i < 500; i++) begin
            logic [15:0] e;
            e = ($urandom % 4 == 0) ? 16'($urandom) : SEL;
            cfg = 9'($urandom);
            access(e, 2'($urandom), 1'($urandom), {$urandom, $urandom}, "R12");
            check_irq("R12");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule